// File: doc/BRIEF.md
# Extended block fill unit

The fill unit sits behind the decoders of a processor front end. It takes in a stream of decoded micro-ops, each carrying the address of its instruction and a small code for the kind of control transfer that instruction performs. It packs them into variable-length extended blocks for a micro-op cache. A block continues past plain micro-ops, unconditional direct jumps and conditional branches that the predictor has marked as strongly biased. It closes on an unbiased conditional branch, an indirect branch, a call, a return, or when the block reaches its fixed capacity of micro-ops.

Each finished block is presented on one output handshake together with three fields. The tag is the address of the block's last instruction. The length is the number of micro-ops it holds. The end reason says why the block closed. The micro-ops are laid out newest first, so the cache can later grow a stored block at its start without moving the micro-ops it already holds. While a finished block waits for the consumer, the input is held off. A synchronous flush drops a block that is still being built.

Top module: `xb_fill_unit`

## Requirements
- R1: Accepting a conditional branch (branch code 2) with the bias flag low, or an indirect branch (code 3), closes the block, and the end reason reads 0.
- R2: Accepting a call (code 4) or a return (code 5) closes the block, and the end reason reads 1.
- R3: Accepting the QUOTA-th micro-op (16 by default) closes the block even when that micro-op is not a branch. The end reason then reads 2, unless that micro-op would close the block by R1 or R2, in which case that reason wins.
- R4: A plain micro-op (code 0) or an unconditional direct jump (code 1) does not close the block while it holds fewer than QUOTA micro-ops.
- R5: A conditional branch with the bias flag high does not close the block. The bias flag has no effect on codes 3, 4 and 5.
- R6: blk_tag equals the instruction address of the last micro-op accepted into the block.
- R7: blk_uops holds the micro-ops newest first. Slot k (bits k*UOP_W+UOP_W-1 down to k*UOP_W) holds the micro-op accepted k positions before the last one, and slots at or beyond the length read zero.
- R8: blk_len shows how many micro-ops the current block holds. With blk_valid high it lies between 1 and QUOTA. After a block is taken it returns to 0.
- R9: While blk_valid is high, in_ready is low. Until blk_ready is seen, every output field stays stable. Each micro-op offered is taken exactly once.
- R10: While flush is high, in_ready is low. A flush with no finished block pending discards the partial block, so blk_len becomes 0. A flush while a finished block waits has no effect on it.
- R11: After reset, blk_valid is 0, blk_len is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of the partial block |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op can be accepted |
| in_uop | input | UOP_W | Decoded micro-op payload |
| in_addr | input | ADDR_W | Address of the instruction the micro-op belongs to |
| in_btype | input | 3 | Control code: 0 none, 1 direct jump, 2 conditional, 3 indirect, 4 call, 5 return |
| in_biased | input | 1 | Conditional branch is strongly biased |
| blk_valid | output | 1 | Finished block presented |
| blk_ready | input | 1 | Consumer takes the block |
| blk_uops | output | QUOTA*UOP_W | Block micro-ops, newest in slot 0 |
| blk_tag | output | ADDR_W | Address of the ending instruction |
| blk_len | output | CNT_W | Micro-op count |
| blk_reason | output | 2 | End reason: 0 branch, 1 call/return, 2 quota |

## Verification
On every cycle the assertions check these properties:
- accepting an unbiased conditional branch, a call or a return closes the block in the next cycle;
- a jump taken before the quota leaves the block open;
- the length stays in range, and a quota reason always comes with a full block;
- the input is held off and every output field is held while a block waits;
- a flush clears only a partial block.

Only the bench scenarios show the following:
- the exact newest-first contents of each slot;
- that the tag matches the last address;
- how the reasons rank when the quota-filling micro-op is also a branch;
- that a micro-op held during a stall ends up in the next block exactly once.

// File: rtl/xbf_pkg.sv
package xbf_pkg;

  typedef enum logic [2:0] {
    BT_NONE = 3'd0,
    BT_JUMP = 3'd1,
    BT_COND = 3'd2,
    BT_IND  = 3'd3,
    BT_CALL = 3'd4,
    BT_RET  = 3'd5
  } xbf_btype_e;

  typedef enum logic [1:0] {
    END_BRANCH  = 2'd0,
    END_CALLRET = 2'd1,
    END_QUOTA   = 2'd2
  } xbf_end_e;

endpackage

// File: rtl/xbf_classify.sv
module xbf_classify
  import xbf_pkg::*;
#(
  parameter int QUOTA = 16,
  parameter int CNT_W = $clog2(QUOTA + 1)
) (
  input  logic [2:0]       btype,
  input  logic             biased,
  input  logic [CNT_W-1:0] count,
  output logic             ends,
  output logic [1:0]       reason
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(QUOTA - 1);

  logic stop_branch;
  logic stop_callret;
  logic stop_quota;

  always_comb begin
    stop_branch  = ((btype == BT_COND) && !biased) || (btype == BT_IND);
    stop_callret = (btype == BT_CALL) || (btype == BT_RET);
    stop_quota   = (count == LAST_SLOT);
    ends         = stop_branch || stop_callret || stop_quota;
    if (stop_branch) begin
      reason = END_BRANCH;
    end else if (stop_callret) begin
      reason = END_CALLRET;
    end else begin
      reason = END_QUOTA;
    end
  end

endmodule

// File: rtl/xbf_rev_store.sv
module xbf_rev_store #(
  parameter int UOP_W = 16,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic                   clear_en,
  input  logic [UOP_W-1:0]       din,
  output logic [DEPTH*UOP_W-1:0] dout
);

  logic [UOP_W-1:0] slot_q [DEPTH];
  logic [UOP_W-1:0] slot_d [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_head
        always_comb begin
          slot_d[g] = slot_q[g];
          if (clear_en) begin
            slot_d[g] = '0;
          end else if (shift_en) begin
            slot_d[g] = din;
          end
        end
      end else begin : g_body
        always_comb begin
          slot_d[g] = slot_q[g];
          if (clear_en) begin
            slot_d[g] = '0;
          end else if (shift_en) begin
            slot_d[g] = slot_q[g-1];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q[g] <= '0;
        end else if (clear_en || shift_en) begin
          slot_q[g] <= slot_d[g];
        end
      end

      assign dout[g*UOP_W +: UOP_W] = slot_q[g];
    end
  endgenerate

endmodule

// File: rtl/xbf_ctrl.sv
module xbf_ctrl #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ends,
  input  logic [1:0]        reason_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              pop,
  input  logic              drop,
  output logic              pending,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] tag,
  output logic [1:0]        reason
);

  logic              pending_d;
  logic [CNT_W-1:0]  count_d;
  logic [ADDR_W-1:0] tag_d;
  logic [1:0]        reason_d;
  logic              upd_en;

  always_comb begin
    pending_d = pending;
    count_d   = count;
    tag_d     = tag;
    reason_d  = reason;
    if (pop) begin
      pending_d = 1'b0;
      count_d   = '0;
    end else if (drop) begin
      count_d   = '0;
    end else if (accept) begin
      count_d   = count + CNT_W'(1);
      tag_d     = addr_in;
      if (ends) begin
        pending_d = 1'b1;
        reason_d  = reason_in;
      end
    end
    upd_en = pop || drop || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      count   <= '0;
      tag     <= '0;
      reason  <= '0;
    end else if (upd_en) begin
      pending <= pending_d;
      count   <= count_d;
      tag     <= tag_d;
      reason  <= reason_d;
    end
  end

endmodule

// File: rtl/xb_fill_unit.sv
module xb_fill_unit #(
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 32,
  parameter int QUOTA  = 16,
  parameter int CNT_W  = $clog2(QUOTA + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [UOP_W-1:0]       in_uop,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [2:0]             in_btype,
  input  logic                   in_biased,
  output logic                   blk_valid,
  input  logic                   blk_ready,
  output logic [QUOTA*UOP_W-1:0] blk_uops,
  output logic [ADDR_W-1:0]      blk_tag,
  output logic [CNT_W-1:0]       blk_len,
  output logic [1:0]             blk_reason
);

  logic             pending;
  logic             accept;
  logic             pop;
  logic             drop;
  logic             ends;
  logic [1:0]       reason_c;
  logic [CNT_W-1:0] count;

  assign in_ready  = !pending && !flush;
  assign accept    = in_valid && in_ready;
  assign pop       = pending && blk_ready;
  assign drop      = flush && !pending;
  assign blk_valid = pending;
  assign blk_len   = count;

  xbf_classify #(.QUOTA(QUOTA), .CNT_W(CNT_W)) u_classify (
    .btype  (in_btype),
    .biased (in_biased),
    .count  (count),
    .ends   (ends),
    .reason (reason_c)
  );

  xbf_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .ends      (ends),
    .reason_in (reason_c),
    .addr_in   (in_addr),
    .pop       (pop),
    .drop      (drop),
    .pending   (pending),
    .count     (count),
    .tag       (blk_tag),
    .reason    (blk_reason)
  );

  xbf_rev_store #(.UOP_W(UOP_W), .DEPTH(QUOTA)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .clear_en (pop || drop),
    .din      (in_uop),
    .dout     (blk_uops)
  );

endmodule

// File: rtl/xb_fill_unit_chk.sv
module xb_fill_unit_chk #(
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 32,
  parameter int QUOTA  = 16,
  parameter int CNT_W  = $clog2(QUOTA + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [2:0]             in_btype,
  input logic                   in_biased,
  input logic                   blk_valid,
  input logic                   blk_ready,
  input logic [QUOTA*UOP_W-1:0] blk_uops,
  input logic [ADDR_W-1:0]      blk_tag,
  input logic [CNT_W-1:0]       blk_len,
  input logic [1:0]             blk_reason
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(QUOTA);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUOTA - 1);

  // R1: unbiased conditional branch closes the block with reason 0
  assert_cond_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_btype == 3'd2 && !in_biased)
      |=> (blk_valid && blk_reason == 2'd0));

  // R2: call or return closes the block with reason 1
  assert_callret_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_btype == 3'd4 || in_btype == 3'd5))
      |=> (blk_valid && blk_reason == 2'd1));

  // R3: a quota reason always means a full block
  assert_quota_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_reason == 2'd2) |-> (blk_len == FULL));

  // R4: a jump before the last slot keeps the block open
  assert_jump_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_btype == 3'd1 && blk_len < LAST)
      |=> !blk_valid);

  // R8: length range
  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_len != '0 && blk_len <= FULL));

  assert_len_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |-> (blk_len < FULL));

  // R9: back-pressure and stable output while stalled
  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !in_ready);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready)
      |=> (blk_valid && $stable(blk_tag) && $stable(blk_len)
           && $stable(blk_reason) && $stable(blk_uops)));

  // R10: flush clears a partial block and blocks input
  assert_flush_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !blk_valid) |=> (!blk_valid && blk_len == '0));

  assert_flush_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

endmodule

bind xb_fill_unit xb_fill_unit_chk #(
  .UOP_W(UOP_W), .ADDR_W(ADDR_W), .QUOTA(QUOTA), .CNT_W(CNT_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_btype   (in_btype),
  .in_biased  (in_biased),
  .blk_valid  (blk_valid),
  .blk_ready  (blk_ready),
  .blk_uops   (blk_uops),
  .blk_tag    (blk_tag),
  .blk_len    (blk_len),
  .blk_reason (blk_reason)
);

// File: tb/test_xb_fill_unit.sv
`timescale 1ns/1ps
module test_xb_fill_unit;

  localparam int UW = 16;
  localparam int AW = 32;
  localparam int Q  = 16;
  localparam int CW = $clog2(Q + 1);

  logic          clk;
  logic          rst_n;
  logic          flush;
  logic          in_valid;
  logic          in_ready;
  logic [UW-1:0] in_uop;
  logic [AW-1:0] in_addr;
  logic [2:0]    in_btype;
  logic          in_biased;
  logic          blk_valid;
  logic          blk_ready;
  logic [Q*UW-1:0] blk_uops;
  logic [AW-1:0] blk_tag;
  logic [CW-1:0] blk_len;
  logic [1:0]    blk_reason;

  int checks = 0;
  int errors = 0;

  xb_fill_unit #(.UOP_W(UW), .ADDR_W(AW), .QUOTA(Q)) i_xb_fill_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_uop(in_uop),
    .in_addr(in_addr), .in_btype(in_btype), .in_biased(in_biased),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_uops(blk_uops),
    .blk_tag(blk_tag), .blk_len(blk_len), .blk_reason(blk_reason)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [UW-1:0] uval(input int base, input int i);
    return UW'(base * 17 + i + 1);
  endfunction

  function automatic logic [AW-1:0] aval(input int base, input int i);
    return AW'(32'h1000_0000 + base * 256 + i * 4);
  endfunction

  task automatic send(input logic [UW-1:0] u, input logic [AW-1:0] a,
                      input int bt, input bit bias);
    in_valid  = 1'b1;
    in_uop    = u;
    in_addr   = a;
    in_btype  = 3'(bt);
    in_biased = bias;
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic verify(input string req, input int len, input logic [AW-1:0] tag,
                        input int reason, input logic [Q*UW-1:0] vec);
    chk(blk_valid == 1'b1, req, "blk_valid", longint'(blk_valid), 1);
    chk(int'(blk_len) == len, "R8", "blk_len", longint'(blk_len), len);
    chk(blk_tag == tag, "R6", "blk_tag", longint'(blk_tag), longint'(tag));
    chk(int'(blk_reason) == reason, req, "blk_reason", longint'(blk_reason), reason);
    for (int k = 0; k < Q; k++) begin
      if (blk_uops[k*UW +: UW] != vec[k*UW +: UW]) begin
        chk(1'b0, "R7", $sformatf("slot %0d", k),
            longint'(blk_uops[k*UW +: UW]), longint'(vec[k*UW +: UW]));
        break;
      end
    end
    checks++;
    blk_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    blk_ready = 1'b0;
    chk(blk_valid == 1'b0 && blk_len == '0, "R8", "cleared after take",
        longint'(blk_len), 0);
  endtask

  // filler pattern: plain (R4), jump (R4), biased conditional (R5)
  task automatic build(input int len, input int term, input bit tbias, input int base);
    logic [Q*UW-1:0] vec;
    int reason;
    vec = '0;
    for (int i = 0; i < len - 1; i++) begin
      case (i % 3)
        0:       send(uval(base, i), aval(base, i), 0, 1'b0);
        1:       send(uval(base, i), aval(base, i), 1, 1'b0);
        default: send(uval(base, i), aval(base, i), 2, 1'b1);
      endcase
    end
    if (len > 1)
      chk(blk_valid == 1'b0 && int'(blk_len) == len - 1, "R4 R5", "open after filler",
          longint'(blk_len), len - 1);
    send(uval(base, len - 1), aval(base, len - 1), term, tbias);
    for (int k = 0; k < len; k++) vec[k*UW +: UW] = uval(base, len - 1 - k);
    if ((term == 2 && !tbias) || term == 3) reason = 0;
    else if (term == 4 || term == 5) reason = 1;
    else reason = 2;
    verify(reason == 0 ? "R1" : (reason == 1 ? "R2" : "R3"),
           len, aval(base, len - 1), reason, vec);
  endtask

  task automatic run_all();
    int base;
    logic [Q*UW-1:0] vec;
    base = 0;
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; blk_ready = 1'b0;
    in_uop = '0; in_addr = '0; in_btype = '0; in_biased = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(blk_valid == 1'b0, "R11", "blk_valid", longint'(blk_valid), 0);
    chk(blk_len == '0, "R11", "blk_len", longint'(blk_len), 0);
    chk(in_ready == 1'b1, "R11", "in_ready", longint'(in_ready), 1);

    // sweep every length with every closing kind (R1 R2 R6 R7 R8)
    for (int len = 1; len <= Q; len++) begin
      for (int t = 2; t <= 5; t++) begin
        build(len, t, 1'b0, base);
        base++;
      end
    end
    // bias ignored on indirect, call, return (R5)
    for (int t = 3; t <= 5; t++) begin
      build(4, t, 1'b1, base);
      base++;
    end
    // quota closes regardless; branch reasons win at the last slot (R3)
    build(Q, 0, 1'b0, base); base++;
    build(Q, 1, 1'b0, base); base++;
    build(Q, 2, 1'b1, base); base++;

    // stall: held micro-op is taken once after the block leaves (R9)
    send(uval(base, 0), aval(base, 0), 0, 1'b0);
    send(uval(base, 1), aval(base, 1), 5, 1'b0);
    in_valid = 1'b1; in_uop = uval(base, 7); in_addr = aval(base, 7);
    in_btype = 3'd0; in_biased = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (c == 2) flush = 1'b1;
      @(posedge clk);
      @(negedge clk);
      flush = 1'b0;
      chk(in_ready == 1'b0, "R9", "in_ready while stalled", longint'(in_ready), 0);
      chk(blk_valid == 1'b1 && int'(blk_len) == 2, "R10", "pending block kept",
          longint'(blk_len), 2);
    end
    chk(blk_tag == aval(base, 1), "R9", "tag held", longint'(blk_tag),
        longint'(aval(base, 1)));
    blk_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    blk_ready = 1'b0;
    chk(blk_len == '0, "R9", "held uop not taken during pop", longint'(blk_len), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(int'(blk_len) == 1, "R9", "held uop taken once", longint'(blk_len), 1);
    send(uval(base, 8), aval(base, 8), 2, 1'b0);
    vec = '0;
    vec[0 +: UW]  = uval(base, 8);
    vec[UW +: UW] = uval(base, 7);
    verify("R9", 2, aval(base, 8), 0, vec);
    base++;

    // flush discards a partial block (R10)
    for (int i = 0; i < 5; i++) send(uval(base, i), aval(base, i), 1, 1'b0);
    flush = 1'b1;
    in_valid = 1'b1; in_uop = uval(base, 9); in_btype = 3'd2;
    #1;
    chk(in_ready == 1'b0, "R10", "in_ready during flush", longint'(in_ready), 1'b0);
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    chk(blk_valid == 1'b0 && blk_len == '0, "R10", "partial dropped",
        longint'(blk_len), 0);
    base++;
    build(3, 2, 1'b0, base);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "timeout", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule